// File: doc/BRIEF.md
# TSF and Beacon Timer Unit

This block keeps a free-running 64-bit time synchronisation counter that advances once per microsecond tick, and four 16-bit beacon event timers that fire against it. The timers hold the next target beacon time, the DMA beacon alert, the software beacon alert and the end of the announcement window. Beacon-time and window-end timers count in time units (TU, 1024 µs, taken as counter bits [25:10]). The two alert timers count in eighths of a TU (counter bits [22:7]).

When beacons are enabled and a timer equals its view of the counter, the block raises that timer's event for one cycle. It also adds the beacon period to the timer, scaled by eight for the eighth-TU timers. Comparison is only 16 bits wide. If the counter jumps past a timer, that timer stalls until the 16-bit unit count wraps back onto it.

Software-style strobes load the counter as a low half followed by a high half, toggle a counter-reset request, write any timer, and set the period and the enable. The low half waits in a shadow register until the high half arrives, so the counter never exposes a half-written value.

Top module: `bcn_tsf_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `tsf_now`, every timer in `tmr_value` and `evt_pulse` read zero, and no counter reset is pending.
- R2: `tsf_now` rises by exactly one after each cycle in which `us_tick` is high. This holds when there is no high-half write and no pending reset. With `us_tick` low, `tsf_now` holds.
- R3: `tsf_lo_wr` changes nothing visible. A later `tsf_hi_wr` sets `tsf_now` to {high data, last low data} in the next cycle. A high-half write wins over a tick in the same cycle.
- R4: Each cycle with `tsf_rst_tgl` high inverts the pending reset request. At the next tick, a pending request clears `tsf_now` to zero instead of incrementing it. A toggle that arrives in the same cycle as the consuming tick becomes the new request. Two toggles before a tick leave no reset.
- R5: Timer 0 (bits [15:0] of `tmr_value`) and timer 3 (bits [63:48]) compare with `tsf_now[25:10]`. On equality with beacons enabled, `evt_pulse[i]` is high in the following cycle only. In that same cycle the timer has advanced by the period, modulo 2^16.
- R6: Timer 1 (bits [31:16]) and timer 2 (bits [47:32]) compare with `tsf_now[22:7]`. On a match they advance by eight times the period, modulo 2^16. The event is raised exactly as in R5.
- R7: While the enable is clear, `evt_pulse` stays zero and the timers hold, even when a timer equals its view of the counter.
- R8: `tmr_wr` loads `tmr_wdata` into the timer selected by `tmr_sel` (0 to 3 as in R5/R6) in the next cycle. The load takes priority over a match-advance of the same timer, but the event for that match is still raised.
- R9: If the counter is moved past a timer, the timer does not advance and no event is raised. It fires again only when the 16 compared unit bits equal it, whatever the higher counter bits are.
- R10: `cfg_wr` loads the period and the enable. Advances use the period held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-microsecond tick strobe |
| tsf_lo_wr | input | 1 | Load `tsf_wdata` into the low-half shadow |
| tsf_hi_wr | input | 1 | Commit {`tsf_wdata`, shadow} to the counter |
| tsf_wdata | input | 32 | Counter half-word write data |
| tsf_rst_tgl | input | 1 | Toggle the pending counter-reset request |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_sel | input | 2 | Timer index for a write |
| tmr_wdata | input | 16 | Timer write data |
| cfg_wr | input | 1 | Period/enable write strobe |
| cfg_period | input | 16 | Beacon period in TU |
| cfg_enable | input | 1 | Beacon event enable |
| tsf_now | output | 64 | Current counter value |
| tmr_value | output | 64 | Four timers, timer i at bits [16i+15:16i] |
| evt_pulse | output | 4 | One-cycle event per timer |

## Verification
The bench builds the block with its default parameters: 16-bit timers, four of them, TU at counter bit 10 and eighth-TU at bit 7. With these values the 16-bit unit wrap can be reached by loading the counter directly, so R9 is exercised without waiting 2^26 ticks. A counter value whose TU field exceeds 65535 still matches on its low 16 bits. An eighth-TU timer near 0xFFF0 is used to show the modulo advance. Loading the counter a couple of ticks before each target shows every timer's event cycle and its advance step.

// File: rtl/bcn_tsf_pkg.sv
package bcn_tsf_pkg;

    localparam int TSF_W  = 64;
    localparam int HALF_W = TSF_W / 2;

    typedef enum logic [1:0] {
        TMR_BEACON    = 2'd0,
        TMR_DMA_ALERT = 2'd1,
        TMR_SW_ALERT  = 2'd2,
        TMR_WIN_END   = 2'd3
    } tmr_id_e;

    typedef struct packed {
        logic              lo;
        logic              hi;
        logic [HALF_W-1:0] data;
    } tsf_wr_t;

    // timers counted in eighths of a TU
    function automatic bit in_eighths(input int idx);
        return (idx == int'(TMR_DMA_ALERT)) || (idx == int'(TMR_SW_ALERT));
    endfunction

endpackage

// File: rtl/bcn_tsf_counter.sv
module bcn_tsf_counter
    import bcn_tsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             us_tick,
    input  tsf_wr_t          wr,
    input  logic             rst_tgl,
    output logic [TSF_W-1:0] tsf_q,
    output logic             rst_pend_q
);

    logic [HALF_W-1:0] shadow_q;
    logic              consume;

    // a tick absorbs a pending reset unless a high-half write takes the cycle
    assign consume = us_tick && rst_pend_q && !wr.hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            tsf_q      <= '0;
            shadow_q   <= '0;
            rst_pend_q <= 1'b0;
        end else begin
            if (wr.lo) begin
                shadow_q <= wr.data;
            end
            if (wr.hi) begin
                tsf_q <= {wr.data, shadow_q};
            end else if (us_tick) begin
                tsf_q <= rst_pend_q ? '0 : tsf_q + TSF_W'(1);
            end
            rst_pend_q <= consume ? rst_tgl : (rst_pend_q ^ rst_tgl);
        end
    end

endmodule

// File: rtl/bcn_evt_timer.sv
module bcn_evt_timer
    import bcn_tsf_pkg::*;
#(
    parameter int TMR_W    = 16,
    parameter int UNIT_LSB = 10,
    parameter int STEP_SH  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TSF_W-1:0] tsf,
    input  logic             en,
    input  logic [TMR_W-1:0] period,
    input  logic             wr,
    input  logic [TMR_W-1:0] wdata,
    output logic [TMR_W-1:0] value_q,
    output logic             evt_q
);

    logic [TMR_W-1:0] unit_now;
    logic [TMR_W-1:0] step;
    logic             hit;

    assign unit_now = tsf[UNIT_LSB +: TMR_W];
    assign step     = period << STEP_SH;
    assign hit      = en && (unit_now == value_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            evt_q   <= 1'b0;
        end else begin
            evt_q <= hit;
            if (wr) begin
                value_q <= wdata;
            end else if (hit) begin
                value_q <= value_q + step;
            end
        end
    end

endmodule

// File: rtl/bcn_tsf_unit.sv
module bcn_tsf_unit
    import bcn_tsf_pkg::*;
#(
    parameter int TMR_W   = 16,
    parameter int N_TMR   = 4,
    parameter int TU_LSB  = 10,
    parameter int ETU_LSB = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      us_tick,
    input  logic                      tsf_lo_wr,
    input  logic                      tsf_hi_wr,
    input  logic [31:0]               tsf_wdata,
    input  logic                      tsf_rst_tgl,
    input  logic                      tmr_wr,
    input  logic [1:0]                tmr_sel,
    input  logic [15:0]               tmr_wdata,
    input  logic                      cfg_wr,
    input  logic [15:0]               cfg_period,
    input  logic                      cfg_enable,
    output logic [63:0]               tsf_now,
    output logic [N_TMR*TMR_W-1:0]    tmr_value,
    output logic [N_TMR-1:0]          evt_pulse
);

    localparam int SCALE_SH = TU_LSB - ETU_LSB;
    localparam int SEL_W    = $clog2(N_TMR);

    tsf_wr_t          tsf_req;
    logic             rst_pend;
    logic [TMR_W-1:0] period_q;
    logic             bcn_en_q;

    assign tsf_req = '{lo: tsf_lo_wr, hi: tsf_hi_wr, data: tsf_wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            bcn_en_q <= 1'b0;
        end else if (cfg_wr) begin
            period_q <= cfg_period;
            bcn_en_q <= cfg_enable;
        end
    end

    bcn_tsf_counter u_tsf (
        .clk       (clk),
        .rst       (rst),
        .us_tick   (us_tick),
        .wr        (tsf_req),
        .rst_tgl   (tsf_rst_tgl),
        .tsf_q     (tsf_now),
        .rst_pend_q(rst_pend)
    );

    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
        localparam bit EIGHTH = in_eighths(gi);
        logic sel_hit;
        assign sel_hit = tmr_wr && (tmr_sel[SEL_W-1:0] == SEL_W'(gi));

        bcn_evt_timer #(
            .TMR_W   (TMR_W),
            .UNIT_LSB(EIGHTH ? ETU_LSB : TU_LSB),
            .STEP_SH (EIGHTH ? SCALE_SH : 0)
        ) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .tsf    (tsf_now),
            .en     (bcn_en_q),
            .period (period_q),
            .wr     (sel_hit),
            .wdata  (tmr_wdata),
            .value_q(tmr_value[gi*TMR_W +: TMR_W]),
            .evt_q  (evt_pulse[gi])
        );
    end

endmodule

// File: rtl/bcn_tsf_unit_chk.sv
module bcn_tsf_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        us_tick,
    input logic        tsf_hi_wr,
    input logic [31:0] tsf_wdata,
    input logic        tmr_wr,
    input logic [1:0]  tmr_sel,
    input logic [15:0] tmr_wdata,
    input logic [63:0] tsf_now,
    input logic [63:0] tmr_value,
    input logic [3:0]  evt_pulse,
    input logic        rst_pend,
    input logic        bcn_en
);

    // R2
    tsf_step_chk: assert property (@(posedge clk) disable iff (rst)
        (us_tick && !tsf_hi_wr && !rst_pend) |=> (tsf_now == $past(tsf_now) + 64'd1));

    // R2
    tsf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!us_tick && !tsf_hi_wr) |=> $stable(tsf_now));

    // R3
    tsf_commit_chk: assert property (@(posedge clk) disable iff (rst)
        tsf_hi_wr |=> (tsf_now[63:32] == $past(tsf_wdata)));

    // R4
    tsf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (us_tick && !tsf_hi_wr && rst_pend) |=> (tsf_now == 64'd0));

    // R7
    evt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !bcn_en |=> (evt_pulse == 4'd0));

    // R8
    tmr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_wr && tmr_sel == 2'd0) |=> (tmr_value[15:0] == $past(tmr_wdata)));

endmodule

bind bcn_tsf_unit bcn_tsf_unit_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .us_tick  (us_tick),
    .tsf_hi_wr(tsf_hi_wr),
    .tsf_wdata(tsf_wdata),
    .tmr_wr   (tmr_wr),
    .tmr_sel  (tmr_sel),
    .tmr_wdata(tmr_wdata),
    .tsf_now  (tsf_now),
    .tmr_value(tmr_value),
    .evt_pulse(evt_pulse),
    .rst_pend (rst_pend),
    .bcn_en   (bcn_en_q)
);

// File: tb/bcn_tsf_unit_tb_top.sv
`timescale 1ns/1ps
module bcn_tsf_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        us_tick = 1'b0;
    logic        tsf_lo_wr = 1'b0;
    logic        tsf_hi_wr = 1'b0;
    logic [31:0] tsf_wdata = '0;
    logic        tsf_rst_tgl = 1'b0;
    logic        tmr_wr = 1'b0;
    logic [1:0]  tmr_sel = '0;
    logic [15:0] tmr_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_period = '0;
    logic        cfg_enable = 1'b0;
    logic [63:0] tsf_now;
    logic [63:0] tmr_value;
    logic [3:0]  evt_pulse;

    always #2 clk = ~clk;

    bcn_tsf_unit dut_i (.*);

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference
    longint unsigned m_tsf = 0;
    longint unsigned m_sh = 0;
    bit              m_pend = 0;
    int              m_tmr[4] = '{0, 0, 0, 0};
    bit [3:0]        m_evt = '0;
    int              m_per = 0;
    bit              m_en = 0;

    task automatic model_step();
        int  nt[4];
        bit  [3:0] ne;
        if (rst) begin
            m_tsf = 0; m_sh = 0; m_pend = 0; m_evt = '0; m_per = 0; m_en = 0;
            foreach (m_tmr[k]) m_tmr[k] = 0;
            return;
        end
        for (int j = 0; j < 4; j++) begin
            bit eighth = (j == 1) || (j == 2);
            int unit = eighth ? int'((m_tsf / 128) % 65536) : int'((m_tsf / 1024) % 65536);
            int stp  = eighth ? (m_per * 8) % 65536 : m_per;
            bit hit  = m_en && (unit == m_tmr[j]);
            ne[j] = hit;
            if (tmr_wr && tmr_sel == 2'(j)) nt[j] = int'(tmr_wdata);
            else if (hit) nt[j] = (m_tmr[j] + stp) % 65536;
            else nt[j] = m_tmr[j];
        end
        if (us_tick && m_pend && !tsf_hi_wr) m_pend = tsf_rst_tgl;
        else if (tsf_rst_tgl) m_pend = !m_pend;
        if (tsf_hi_wr) m_tsf = (longint'(tsf_wdata) << 32) | m_sh;
        else if (us_tick) m_tsf = (m_pend_before_tick) ? 0 : m_tsf + 1;
        if (tsf_lo_wr) m_sh = longint'(tsf_wdata);
        if (cfg_wr) begin m_per = int'(cfg_period); m_en = cfg_enable; end
        m_tmr = nt;
        m_evt = ne;
    endtask

    bit m_pend_before_tick;

    task automatic check64(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        m_pend_before_tick = m_pend;
        model_step();
        @(negedge clk);
        check64(cur_req, "tsf", tsf_now, m_tsf);
        check64(cur_req, "timers", tmr_value,
                {16'(m_tmr[3]), 16'(m_tmr[2]), 16'(m_tmr[1]), 16'(m_tmr[0])});
        check64(cur_req, "events", {60'd0, evt_pulse}, {60'd0, m_evt});
        us_tick = 0; tsf_lo_wr = 0; tsf_hi_wr = 0; tsf_rst_tgl = 0;
        tmr_wr = 0; cfg_wr = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin us_tick = 1; cyc(); end
    endtask

    task automatic wr_tsf(input logic [31:0] hi, input logic [31:0] lo);
        tsf_lo_wr = 1; tsf_wdata = lo; cyc();
        tsf_hi_wr = 1; tsf_wdata = hi; cyc();
    endtask

    task automatic wr_tmr(input logic [1:0] sel, input logic [15:0] val);
        tmr_wr = 1; tmr_sel = sel; tmr_wdata = val; cyc();
    endtask

    task automatic wr_cfg(input logic [15:0] per, input logic en);
        cfg_wr = 1; cfg_period = per; cfg_enable = en; cyc();
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R1";
        rst = 1; cyc(); cyc(); cyc();
        check64("R1", "tsf in reset", tsf_now, 64'd0);
        rst = 0; cyc();
        check64("R1", "tsf after reset", tsf_now, 64'd0);
        check64("R1", "timers after reset", tmr_value, 64'd0);
        check64("R1", "events after reset", {60'd0, evt_pulse}, 64'd0);

        cur_req = "R2";
        ticks(4); cyc(); ticks(2);
        check64("R2", "tsf after 6 ticks", tsf_now, 64'd6);

        cur_req = "R3";
        tsf_lo_wr = 1; tsf_wdata = 32'h0000_13FD; cyc();
        check64("R3", "low write alone", tsf_now, 64'd6);
        tsf_hi_wr = 1; tsf_wdata = 32'h1; cyc();
        check64("R3", "high commit", tsf_now, 64'h1_0000_13FD);
        tsf_hi_wr = 1; tsf_wdata = 32'h2; us_tick = 1; cyc();
        check64("R3", "write beats tick", tsf_now, 64'h2_0000_13FD);

        cur_req = "R4";
        tsf_rst_tgl = 1; cyc();
        ticks(1);
        check64("R4", "single toggle clears", tsf_now, 64'd0);
        tsf_rst_tgl = 1; cyc(); tsf_rst_tgl = 1; cyc();
        ticks(1);
        check64("R4", "double toggle no clear", tsf_now, 64'd1);
        tsf_rst_tgl = 1; us_tick = 1; cyc();
        check64("R4", "toggle with tick", tsf_now, 64'd2);
        ticks(1);
        check64("R4", "pending consumed", tsf_now, 64'd0);

        cur_req = "R7";
        wr_tsf(32'h0, 32'h1400);
        wr_tmr(2'd0, 16'd5);
        ticks(3);
        check64("R7", "no event when disabled", {60'd0, evt_pulse}, 64'd0);
        check64("R7", "timer held when disabled", {48'd0, tmr_value[15:0]}, 64'd5);

        cur_req = "R10";
        wr_cfg(16'd100, 1'b1);
        check64("R10", "no event on enable cycle", {60'd0, evt_pulse}, 64'd0);
        cur_req = "R5";
        cyc();
        check64("R5", "timer0 event", {63'd0, evt_pulse[0]}, 64'd1);
        check64("R5", "timer0 advanced", {48'd0, tmr_value[15:0]}, 64'd105);
        cyc();
        check64("R5", "timer0 event one cycle", {63'd0, evt_pulse[0]}, 64'd0);
        wr_tsf(32'h0, 32'd6142);
        wr_tmr(2'd3, 16'd6);
        ticks(3);
        check64("R5", "timer3 event", {63'd0, evt_pulse[3]}, 64'd1);
        check64("R5", "timer3 advanced", {48'd0, tmr_value[63:48]}, 64'd106);

        cur_req = "R6";
        wr_tsf(32'h0, 32'd6399);
        wr_tmr(2'd1, 16'd50);
        ticks(2);
        check64("R6", "timer1 event", {63'd0, evt_pulse[1]}, 64'd1);
        check64("R6", "timer1 advanced x8", {48'd0, tmr_value[31:16]}, 64'd850);
        wr_tsf(32'h0, 32'h007F_F800);
        wr_tmr(2'd2, 16'hFFF0);
        cyc();
        check64("R6", "timer2 event", {63'd0, evt_pulse[2]}, 64'd1);
        check64("R6", "timer2 wraps", {48'd0, tmr_value[47:32]}, 64'h0310);

        cur_req = "R9";
        wr_tmr(2'd0, 16'd200);
        wr_tsf(32'h0, 32'd307200);
        ticks(20);
        check64("R9", "stalled timer no event", {60'd0, evt_pulse}, 64'd0);
        check64("R9", "stalled timer holds", {48'd0, tmr_value[15:0]}, 64'd200);
        wr_tsf(32'h0, 32'd67313664);
        cyc();
        check64("R9", "16-bit match above 65535 TU", {63'd0, evt_pulse[0]}, 64'd1);
        check64("R9", "timer0 advanced after wrap", {48'd0, tmr_value[15:0]}, 64'd300);

        cur_req = "R8";
        wr_tmr(2'd0, 16'd200);
        wr_tmr(2'd0, 16'd777);
        check64("R8", "event kept on load", {63'd0, evt_pulse[0]}, 64'd1);
        check64("R8", "load beats advance", {48'd0, tmr_value[15:0]}, 64'd777);

        cur_req = "R10";
        wr_cfg(16'd10, 1'b1);
        wr_tmr(2'd0, 16'd200);
        cyc();
        check64("R10", "new period used", {48'd0, tmr_value[15:0]}, 64'd210);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule